// File: doc/BRIEF.md
# Buffered Serial EEPROM Byte Logger

This block sits between a fast byte producer and a slow two-wire serial EEPROM. The producer offers one byte per clock into an internal synchronous FIFO and never waits unless the FIFO is full. A background sequencer takes the byte at the head of the FIFO and writes it to the EEPROM through a byte-level command port. Each write is one transaction: a START carrying the device's write-control byte, the memory address bytes, the data byte, then a STOP. A separate bit engine carries out each command and answers with a done pulse and an acknowledge result.

After every STOP the EEPROM is busy programming. The sequencer therefore counts a fixed number of clock cycles before it issues anything new, so the drain rate is set by that fixed busy interval rather than by a handshake. The target address starts at a base value, moves up by one after each acknowledged write and wraps at the memory size. If any byte is not acknowledged, the transaction is cut short with a STOP. The same byte is then retried at the same address after the busy interval, and it stays in the FIFO until its write is acknowledged.

Top module: `eeprom_log_buffer`

## Requirements
- R1: Accepted bytes are written to the EEPROM in the order in which they were pushed, and bytes that were dropped never appear.
- R2: `fifo_empty` is high when no byte is held and `fifo_full` is high when FIFO_DEPTH bytes are held. Both flags are registered and follow the push and pop of the previous clock.
- R3: A push while `fifo_full` is high is dropped and sets `overflow`, which stays high until reset.
- R4: Each write transaction issues, in order: op START (`cmd_op`=0) with byte {DEV_ADDR, 1'b0}, then ADDR_BYTES op BYTE (`cmd_op`=1) commands, then an op BYTE with the data, then op STOP (`cmd_op`=2).
- R5: Once `cmd_valid` is raised, it stays high with `cmd_op` and `cmd_byte` unchanged until the clock in which `cmd_done` is seen.
- R6: After the cycle in which a STOP completes, no new command is raised for at least TWC_CYCLES clock cycles.
- R7: The memory address bytes are sent most significant first. The first write goes to BASE_ADDR, each acknowledged write advances the address by one, and the address after MEM_SIZE-1 is 0.
- R8: `cmd_nack` with `cmd_done` on a START or BYTE command makes the next command a STOP, with no further bytes sent in that transaction.
- R9: A byte whose write was not acknowledged stays in the FIFO and is retried at the same address after the busy interval.
- R10: `idle` is high only while the FIFO is empty and no transaction or busy wait is in progress. After reset, `idle`=1, `fifo_empty`=1, `fifo_full`=0, `overflow`=0 and `cmd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Producer offers a byte this cycle |
| push_data | input | 8 | Byte offered by the producer |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| overflow | output | 1 | Sticky: a push was dropped while full |
| cmd_valid | output | 1 | A bus command is presented |
| cmd_op | output | 2 | Command kind: 0 START, 1 BYTE, 2 STOP |
| cmd_byte | output | 8 | Byte sent with START or BYTE |
| cmd_done | input | 1 | One-cycle pulse: the presented command has finished |
| cmd_nack | input | 1 | With cmd_done: the byte was not acknowledged |
| idle | output | 1 | Nothing buffered, no transaction, no busy wait |

## Verification
The hardest case to reach from the ports is a refused byte partway through a transaction while the FIFO still holds that byte. The observable results are an early STOP, a full busy wait during which `fifo_empty` stays low, and a retry that reuses the same address without skipping it. The bench's model of the bit engine can be armed to refuse the command at a chosen position within the next transaction. Separate scenarios refuse an address byte and the data byte, and each then follows the aborted command stream, the retained byte and the retried write. The address wrap is reached by starting close to a small MEM_SIZE and pushing a burst that also overruns the FIFO.

// File: rtl/eelog_pkg.sv
package eelog_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] data;
    } bus_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR,
        SQ_DATA,
        SQ_STOP,
        SQ_WAIT
    } seq_state_e;

    // write-direction control byte: 7-bit device address, R/W bit low
    function automatic logic [7:0] write_ctrl(input logic [6:0] dev);
        return {dev, 1'b0};
    endfunction

endpackage

// File: rtl/eelog_fifo.sv
module eelog_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         overflow
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end

    p_drop_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
        push && full |=> overflow);
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    p_full_clears_r2: assert property (@(posedge clk) disable iff (rst)
        full && pop && !push |=> !full);
    p_pop_has_data_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/eelog_wait_timer.sv
module eelog_wait_timer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int TW = (CYCLES < 1) ? 1 : $clog2(CYCLES + 1);

    logic [TW-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= TW'(CYCLES);
        else if (!expired)   cnt <= cnt - 1'b1;
    end

    generate
        if (CYCLES > 0) begin : g_busy_chk
            p_load_busy_r6: assert property (@(posedge clk) disable iff (rst)
                load |=> !expired);
        end
    endgenerate

endmodule

// File: rtl/eelog_seq.sv
module eelog_seq
    import eelog_pkg::*;
#(
    parameter int         ADDR_BYTES = 2,
    parameter int         MEM_SIZE   = 32768,
    parameter int         BASE_ADDR  = 0,
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter int         TWC_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_head,
    output logic       fifo_pop,
    output logic       tmr_load,
    input  logic       tmr_expired,
    output logic       cmd_valid,
    output bus_cmd_t   cmd,
    input  logic       cmd_done,
    input  logic       cmd_nack,
    output logic       idle
);
    localparam int AW = ADDR_BYTES * 8;
    localparam int IW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int GW = $clog2(TWC_CYCLES + 2);

    seq_state_e    state;
    logic [AW-1:0] addr_q;
    logic [IW-1:0] idx;
    logic          failed;
    logic [7:0]    addr_lane [ADDR_BYTES];

    // lane 0 carries the most significant address byte
    generate
        for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
            assign addr_lane[g] = addr_q[(ADDR_BYTES-1-g)*8 +: 8];
        end
    endgenerate

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return (a == AW'(MEM_SIZE - 1)) ? '0 : a + 1'b1;
    endfunction

    always_comb begin
        cmd_valid = 1'b1;
        cmd       = '{op: OP_STOP, data: 8'h00};
        case (state)
            SQ_START: cmd = '{op: OP_START, data: write_ctrl(DEV_ADDR)};
            SQ_ADDR:  cmd = '{op: OP_BYTE,  data: addr_lane[idx]};
            SQ_DATA:  cmd = '{op: OP_BYTE,  data: fifo_head};
            SQ_STOP:  cmd = '{op: OP_STOP,  data: 8'h00};
            default:  cmd_valid = 1'b0;
        endcase
    end

    assign tmr_load = (state == SQ_STOP) && cmd_done;
    assign fifo_pop = tmr_load && !failed;
    assign idle     = (state == SQ_IDLE) && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            addr_q <= AW'(BASE_ADDR);
            idx    <= '0;
            failed <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    failed <= 1'b0;
                    if (!fifo_empty) state <= SQ_START;
                end
                SQ_START: if (cmd_done) begin
                    idx <= '0;
                    if (cmd_nack) begin
                        failed <= 1'b1;
                        state  <= SQ_STOP;
                    end else begin
                        state  <= SQ_ADDR;
                    end
                end
                SQ_ADDR: if (cmd_done) begin
                    if (cmd_nack) begin
                        failed <= 1'b1;
                        state  <= SQ_STOP;
                    end else if (idx == IW'(ADDR_BYTES - 1)) begin
                        state  <= SQ_DATA;
                    end else begin
                        idx    <= idx + 1'b1;
                    end
                end
                SQ_DATA: if (cmd_done) begin
                    if (cmd_nack) failed <= 1'b1;
                    state <= SQ_STOP;
                end
                SQ_STOP: if (cmd_done) begin
                    if (!failed) addr_q <= next_addr(addr_q);
                    state <= SQ_WAIT;
                end
                SQ_WAIT: if (tmr_expired) begin
                    failed <= 1'b0;
                    state  <= fifo_empty ? SQ_IDLE : SQ_START;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // cycles since the last completed STOP, kept only for the gap check
    logic [GW-1:0] gap_cnt;
    logic          seen_stop;
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt   <= '0;
            seen_stop <= 1'b0;
        end else if (tmr_load) begin
            gap_cnt   <= '0;
            seen_stop <= 1'b1;
        end else if (gap_cnt != GW'(TWC_CYCLES + 1)) begin
            gap_cnt   <= gap_cnt + 1'b1;
        end
    end

    p_twc_gap_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) && seen_stop |-> gap_cnt >= GW'(TWC_CYCLES));
    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd));
    p_nack_stop_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_done && cmd_nack && cmd.op != OP_STOP
        |=> cmd_valid && cmd.op == OP_STOP);
    p_start_first_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_valid) |-> cmd.op == OP_START);

endmodule

// File: rtl/eeprom_log_buffer.sv
module eeprom_log_buffer
    import eelog_pkg::*;
#(
    parameter int         FIFO_DEPTH = 16,
    parameter int         ADDR_BYTES = 2,
    parameter int         MEM_SIZE   = 32768,
    parameter int         BASE_ADDR  = 0,
    parameter logic [6:0] DEV_ADDR   = 7'h50,
    parameter int         TWC_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_valid,
    input  logic [7:0] push_data,
    output logic       fifo_full,
    output logic       fifo_empty,
    output logic       overflow,
    output logic       cmd_valid,
    output logic [1:0] cmd_op,
    output logic [7:0] cmd_byte,
    input  logic       cmd_done,
    input  logic       cmd_nack,
    output logic       idle
);
    logic [7:0] head;
    logic       pop, tmr_load, tmr_expired;
    bus_cmd_t   cmd;

    eelog_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_valid),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .overflow  (overflow)
    );

    eelog_wait_timer #(.CYCLES(TWC_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    eelog_seq #(
        .ADDR_BYTES (ADDR_BYTES),
        .MEM_SIZE   (MEM_SIZE),
        .BASE_ADDR  (BASE_ADDR),
        .DEV_ADDR   (DEV_ADDR),
        .TWC_CYCLES (TWC_CYCLES)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .fifo_empty  (fifo_empty),
        .fifo_head   (head),
        .fifo_pop    (pop),
        .tmr_load    (tmr_load),
        .tmr_expired (tmr_expired),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .cmd_done    (cmd_done),
        .cmd_nack    (cmd_nack),
        .idle        (idle)
    );

    assign cmd_op   = cmd.op;
    assign cmd_byte = cmd.data;

endmodule

// File: tb/sim_eeprom_log_buffer.sv
module sim_eeprom_log_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int MEMSZ      = 6;
    localparam int BASE       = 4;
    localparam int TWC        = 20;
    localparam int ENG_LAT    = 2;
    localparam logic [7:0] CTRL = 8'hA0;

    logic clk = 0, rst = 1;
    logic push_valid = 0;
    logic [7:0] push_data = 0;
    logic fifo_full, fifo_empty, overflow, cmd_valid, idle;
    logic [1:0] cmd_op;
    logic [7:0] cmd_byte;
    logic cmd_done = 0, cmd_nack = 0;

    int checks = 0, fails = 0, cyc = 0;
    int hold_err = 0, lat = 0, pos = 0, nack_pos = -1;
    logic [1:0] h_op;
    logic [7:0] h_byte;
    logic [1:0] log_op   [64];
    logic [7:0] log_byte [64];
    int         log_cyc  [64];
    int log_cnt = 0, lp = 0;

    eeprom_log_buffer #(
        .FIFO_DEPTH(DEPTH), .ADDR_BYTES(2), .MEM_SIZE(MEMSZ),
        .BASE_ADDR(BASE), .DEV_ADDR(7'h50), .TWC_CYCLES(TWC)
    ) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .overflow(overflow),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .cmd_done(cmd_done), .cmd_nack(cmd_nack), .idle(idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    // model of the bit engine: finishes each command ENG_LAT cycles after it appears
    always @(negedge clk) begin
        cmd_done = 0;
        cmd_nack = 0;
        if (!rst && cmd_valid) begin
            if (lat == 0) begin
                h_op = cmd_op;
                h_byte = cmd_byte;
            end else if (cmd_op != h_op || cmd_byte != h_byte) begin
                hold_err++;
            end
            if (lat == ENG_LAT) begin
                cmd_done = 1;
                if (cmd_op == 2'd0) pos = 0;
                if (cmd_op != 2'd2 && nack_pos == pos) begin
                    cmd_nack = 1;
                    nack_pos = -1;
                end
                if (log_cnt < 64) begin
                    log_op[log_cnt]   = cmd_op;
                    log_byte[log_cnt] = cmd_byte;
                    log_cyc[log_cnt]  = cyc;
                    log_cnt++;
                end
                pos++;
                lat = 0;
            end else begin
                lat++;
            end
        end else begin
            lat = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_log(input int n);
        while (log_cnt < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!idle);
    endtask

    task automatic push(input logic [7:0] d);
        push_valid = 1;
        push_data = d;
        @(negedge clk);
        push_valid = 0;
    endtask

    task automatic expect_xact(input int addr, input int data);
        wait_log(lp + 5);
        check(log_op[lp] == 2'd0 && log_byte[lp] == CTRL, "R4 start ctrl byte", log_byte[lp], CTRL);
        check(log_op[lp+1] == 2'd1 && log_byte[lp+1] == 8'((addr >> 8) & 8'hFF),
              "R7 address high byte", log_byte[lp+1], (addr >> 8) & 8'hFF);
        check(log_op[lp+2] == 2'd1 && log_byte[lp+2] == 8'(addr & 8'hFF),
              "R7 address low byte", log_byte[lp+2], addr & 8'hFF);
        check(log_op[lp+3] == 2'd1 && log_byte[lp+3] == 8'(data),
              "R1 data byte in push order", log_byte[lp+3], data);
        check(log_op[lp+4] == 2'd2, "R4 stop closes write", log_op[lp+4], 2);
        if (lp > 0)
            check(log_cyc[lp] - log_cyc[lp-1] >= TWC, "R6 busy gap before start",
                  log_cyc[lp] - log_cyc[lp-1], TWC);
        lp += 5;
    endtask

    task automatic expect_abort(input int npos);
        wait_log(lp + npos + 2);
        check(log_op[lp] == 2'd0, "R8 aborted write began with start", log_op[lp], 0);
        check(log_op[lp+npos+1] == 2'd2, "R8 stop follows refused byte",
              log_op[lp+npos+1], 2);
        lp += npos + 2;
    endtask

    task automatic t_reset();
        check(idle == 1, "R10 idle after reset", idle, 1);
        check(fifo_empty == 1 && fifo_full == 0, "R2 flags after reset",
              {fifo_full, fifo_empty}, 2'b01);
        check(overflow == 0, "R3 overflow clear after reset", overflow, 0);
        check(cmd_valid == 0, "R10 no command after reset", cmd_valid, 0);
    endtask

    task automatic t_single();
        push(8'h11);
        check(idle == 0 && fifo_empty == 0, "R10 busy once a byte is held", idle, 0);
        expect_xact(BASE, 8'h11);
        wait_idle();
        check(fifo_empty == 1, "R2 empty after drain", fifo_empty, 1);
    endtask

    task automatic t_burst();
        for (int i = 0; i < 6; i++) begin
            push_valid = 1;
            push_data = 8'h20 + 8'(i);
            @(negedge clk);
            if (i == 3) check(fifo_full == 1, "R2 full at depth", fifo_full, 1);
        end
        push_valid = 0;
        check(overflow == 1, "R3 overflow after push while full", overflow, 1);
        expect_xact(5, 8'h20);
        expect_xact(0, 8'h21);   // R7 wrap past MEM_SIZE-1
        expect_xact(1, 8'h22);
        expect_xact(2, 8'h23);
        wait_idle();
        repeat (5) @(negedge clk);
        check(log_cnt == lp, "R1 dropped bytes never written", log_cnt, lp);
        check(overflow == 1, "R3 overflow stays set", overflow, 1);
    endtask

    task automatic t_nack(input int npos, input int addr, input logic [7:0] d);
        nack_pos = npos;
        push(d);
        expect_abort(npos);
        repeat (3) @(negedge clk);
        check(fifo_empty == 0, "R9 refused byte retained", fifo_empty, 0);
        check(idle == 0 && cmd_valid == 0, "R10 waiting after abort",
              {idle, cmd_valid}, 0);
        expect_xact(addr, d);   // R9 same address retried
        wait_idle();
        check(fifo_empty == 1, "R9 byte released after ack", fifo_empty, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_nack(1, 3, 8'h5A);
        t_nack(3, 4, 8'hC3);
        check(hold_err == 0, "R5 command stable until done", hold_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule